// File: doc/BRIEF.md
# Buffered Automatic Serial Transfer Controller

This block is a serial master with an internal 32-byte buffer. Software loads the buffer with the bytes to send and programs the index of the final byte. It then writes a start bit. From that point the controller runs the whole block on its own. For each buffer entry it loads the byte into an 8-bit shift register and shifts it out MSB first on a divided serial clock. While doing so it samples the incoming line, and it stores the received byte back into the entry the transmit byte came from.

A transfer counter steps from zero up to the final index. One interrupt pulse marks the end of the whole block, so the processor is involved only at set-up and at completion. All configuration and the buffer sit in one small address space, reached through a single-cycle write port and a combinational read port.

Top module: `autoxfer`

## Requirements
- R1: After reset: busy reads 0, the interrupt is low, the serial clock and serial data out are low, and the counter, the final-index register and the mode register read 0. The divider register reads DIV_RESET (default 1).
- R2: A start write is honoured only when the mode register has all three of these bits set: bit 0 (automatic operation), bit 1 (transmit enable) and bit 2 (receive enable). With any of them clear, the start is ignored: busy stays 0, the serial clock does not toggle and no interrupt occurs.
- R3: On an accepted start the counter reads 0, and entry 0 is transmitted first. Entries are sent in increasing index order, each MSB first. Serial data out changes only while the serial clock is low, and serial data in is sampled on the rising serial-clock edge.
- R4: The final-index register holds byte count minus one. A transfer moves exactly that value plus one bytes, and the counter then holds the final index.
- R5: Each received byte overwrites the buffer entry at the index its transmit byte was read from. Entries above the final index keep their contents.
- R6: The interrupt is a single one-cycle pulse. It is raised only after the last received byte has been stored, with busy already 0 in that cycle, and it is never raised at start or between bytes.
- R7: Each serial-clock high phase and each low phase inside a byte lasts the divider value plus one system clocks. The serial clock idles low.
- R8: A start write while a transfer is busy is ignored. The counter keeps running and exactly one interrupt still follows.
- R9: While busy, writes to the mode, final-index and divider registers and to the buffer are ignored.
- R10: Address map: offsets 0 to 31 are the buffer, 32 is mode, 33 is the final index (bits 4:0), 34 is control, 35 is the counter (read) and 36 is the divider. At offset 34, a write of bit 0 = 1 requests a start, and a read returns busy in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe for the register/buffer port |
| busAddr | input | ADDR_W | Register or buffer offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in, sampled on the rising serial-clock edge |
| irq | output | 1 | One-cycle end-of-block interrupt |

## Verification
The assertions check, on every cycle, the properties of the transfer sequencing. The interrupt is a lone pulse that coincides with busy being low and the counter sitting at the final index. The counter never passes the final index and only ever steps up by one. The final index holds still during a transfer, and the serial clock stays low when idle. Only the bench scenarios can show that the right bytes appear on the line in the right order and that the received bytes land in the right entries. The same holds for the untouched entries above the final index, the timing of each serial-clock phase, and the rejection of starts and writes under an incomplete mode or during a busy transfer.

// File: rtl/autoxfer_pkg.sv
package autoxfer_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STORE = 2'd3
  } xferState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clrIdx;
    logic loadTx;
    logic shiftEn;
    logic writeRx;
    logic incIdx;
  } xferStrobes_t;

endpackage

// File: rtl/autoxfer_ctrl.sv
module autoxfer_ctrl
  import autoxfer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         byteDone,
  input  logic         atLast,
  output xferStrobes_t strb,
  output logic         busy,
  output logic         irq
);

  xferState_t state, stateNext;
  logic       irqNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    irqNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.clrIdx = 1'b1;
          stateNext   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.loadTx = 1'b1;
        stateNext   = ST_SHIFT;
      end
      ST_SHIFT: begin
        strb.shiftEn = 1'b1;
        if (byteDone) stateNext = ST_STORE;
      end
      ST_STORE: begin
        strb.writeRx = 1'b1;
        if (atLast) begin
          irqNext   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strb.incIdx = 1'b1;
          stateNext   = ST_LOAD;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      irq   <= irqNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/autoxfer_dpath.sv
module autoxfer_dpath
  import autoxfer_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1,
  parameter int ADDR_W    = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWrEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [BYTE_W-1:0]            busWrData,
  output logic [BYTE_W-1:0]            busRdData,
  input  xferStrobes_t                 strb,
  input  logic                         busy,
  output logic                         startReq,
  output logic                         byteDone,
  output logic                         atLast,
  output logic [$clog2(BUF_DEPTH)-1:0] xferIdx,
  output logic [$clog2(BUF_DEPTH)-1:0] lastPtr,
  output logic                         sclk,
  output logic                         mosi,
  input  logic                         miso
);

  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(BUF_DEPTH);
  localparam logic [ADDR_W-1:0] ADDR_LAST  = ADDR_W'(BUF_DEPTH + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(BUF_DEPTH + 2);
  localparam logic [ADDR_W-1:0] ADDR_COUNT = ADDR_W'(BUF_DEPTH + 3);
  localparam logic [ADDR_W-1:0] ADDR_DIV   = ADDR_W'(BUF_DEPTH + 4);

  // configuration
  logic             autoSel, txEn, rxEn;
  logic [DIV_W-1:0] divVal;
  logic             cfgWr, isBufAddr, modeOk;

  assign cfgWr     = busWrEn && !busy;
  assign isBufAddr = (busAddr < ADDR_W'(BUF_DEPTH));
  assign modeOk    = autoSel && txEn && rxEn;
  assign startReq  = busWrEn && (busAddr == ADDR_CTRL) && busWrData[0] && modeOk && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoSel <= 1'b0;
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      lastPtr <= '0;
      divVal  <= DIV_W'(DIV_RESET);
    end else if (cfgWr) begin
      if (busAddr == ADDR_MODE) begin
        autoSel <= busWrData[0];
        txEn    <= busWrData[1];
        rxEn    <= busWrData[2];
      end
      if (busAddr == ADDR_LAST) lastPtr <= busWrData[IDX_W-1:0];
      if (busAddr == ADDR_DIV)  divVal  <= busWrData[DIV_W-1:0];
    end
  end

  // transfer counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            xferIdx <= '0;
    else if (strb.clrIdx) xferIdx <= '0;
    else if (strb.incIdx) xferIdx <= xferIdx + 1'b1;
  end
  assign atLast = (xferIdx == lastPtr);

  // shift engine
  logic [BYTE_W-1:0] shiftReg;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              sclkQ, rxBit, halfEnd;
  logic [BYTE_W-1:0] bufMem [BUF_DEPTH];

  assign halfEnd  = (divCnt == divVal);
  assign byteDone = strb.shiftEn && halfEnd && sclkQ && (bitCnt == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      sclkQ    <= 1'b0;
      rxBit    <= 1'b0;
    end else if (strb.loadTx) begin
      shiftReg <= bufMem[xferIdx];
      divCnt   <= '0;
      bitCnt   <= '0;
      sclkQ    <= 1'b0;
    end else if (strb.shiftEn) begin
      if (halfEnd) begin
        divCnt <= '0;
        sclkQ  <= ~sclkQ;
        if (!sclkQ) begin
          rxBit <= miso;                         // rising edge: sample
        end else begin
          shiftReg <= {shiftReg[BYTE_W-2:0], rxBit}; // falling edge: advance
          bitCnt   <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign sclk = sclkQ;
  assign mosi = busy ? shiftReg[BYTE_W-1] : 1'b0;

  // buffer entries
  for (genvar gi = 0; gi < BUF_DEPTH; gi++) begin : gEntry
    logic seqHit, busHit;
    assign seqHit = strb.writeRx && (xferIdx == IDX_W'(gi));
    assign busHit = cfgWr && isBufAddr && (busAddr[IDX_W-1:0] == IDX_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       bufMem[gi] <= '0;
      else if (seqHit) bufMem[gi] <= shiftReg;
      else if (busHit) bufMem[gi] <= busWrData;
    end
  end

  // read mux
  always_comb begin
    busRdData = '0;
    if (isBufAddr) busRdData = bufMem[busAddr[IDX_W-1:0]];
    else begin
      unique case (busAddr)
        ADDR_MODE:  busRdData = BYTE_W'({rxEn, txEn, autoSel});
        ADDR_LAST:  busRdData = BYTE_W'(lastPtr);
        ADDR_CTRL:  busRdData = BYTE_W'(busy);
        ADDR_COUNT: busRdData = BYTE_W'(xferIdx);
        ADDR_DIV:   busRdData = BYTE_W'(divVal);
        default:    busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/autoxfer.sv
module autoxfer
  import autoxfer_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  xferStrobes_t     strb;
  logic             busy, startReq, byteDone, atLast;
  logic [IDX_W-1:0] xferIdx, lastPtr;

  autoxfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .byteDone (byteDone),
    .atLast   (atLast),
    .strb     (strb),
    .busy     (busy),
    .irq      (irq)
  );

  autoxfer_dpath #(
    .BUF_DEPTH (BUF_DEPTH),
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET),
    .ADDR_W    (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .strb      (strb),
    .busy      (busy),
    .startReq  (startReq),
    .byteDone  (byteDone),
    .atLast    (atLast),
    .xferIdx   (xferIdx),
    .lastPtr   (lastPtr),
    .sclk      (sclk),
    .mosi      (mosi),
    .miso      (miso)
  );

endmodule

// File: rtl/autoxfer_chk.sv
module autoxfer_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic             busy,
  input logic             sclk,
  input logic [IDX_W-1:0] xferIdx,
  input logic [IDX_W-1:0] lastPtr
);

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R6

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy); // R6

  AST_IRQ_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (xferIdx == lastPtr)); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (xferIdx <= lastPtr)); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (xferIdx != $past(xferIdx))) |-> (xferIdx == $past(xferIdx) + 1'b1)); // R3

  AST_LAST_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(lastPtr)); // R9

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk); // R7

endmodule

bind autoxfer autoxfer_chk #(.IDX_W($clog2(BUF_DEPTH))) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irq     (irq),
  .busy    (busy),
  .sclk    (sclk),
  .xferIdx (xferIdx),
  .lastPtr (lastPtr)
);

// File: tb/autoxfer_test.sv
`timescale 1ns/1ps
module autoxfer_test;

  localparam int A_MODE = 32, A_LAST = 33, A_CTRL = 34, A_CNT = 35, A_DIV = 36;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       sclk, mosi, miso, irq;

  int tests = 0, fails = 0;

  always #2 clk = ~clk; // 250 MHz

  autoxfer uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sclk(sclk),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  function automatic logic [7:0] txp(int k, int last);
    return 8'(k * 29 + last * 3 + 7);
  endfunction
  function automatic logic [7:0] rxp(int k);
    return 8'((k * 53 + 60) ^ 150);
  endfunction

  // slave model and monitors
  int         base = 0;
  int         capBits = 0, misoBits = 0, sclkRises = 0;
  logic [7:0] capSh = '0;
  logic [7:0] capArr [64];
  int         irqCnt = 0, hiCnt = 0, badHigh = 0, expHigh = 2;

  always @(posedge sclk) begin
    capSh = {capSh[6:0], mosi};
    capBits++;
    sclkRises++;
    if (capBits % 8 == 0) begin
      if ((capBits / 8 - 1 - base) >= 0 && (capBits / 8 - 1 - base) < 64)
        capArr[capBits / 8 - 1 - base] = capSh;
    end
  end
  always @(negedge sclk) misoBits++;
  assign miso = rxp(misoBits / 8 - base)[7 - (misoBits % 8)];

  always @(negedge clk) begin
    if (irq) irqCnt++;
    if (sclk) hiCnt++;
    else if (hiCnt != 0) begin
      if (hiCnt != expHigh) badHigh++;
      hiCnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 6'(a); busWrData = 8'(d);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output int d);
    @(negedge clk);
    busAddr = 6'(a);
    #1 d = int'(busRdData);
  endtask

  task automatic runXfer(input int last, input int div, input bit poke);
    int v, irq0, bad0, ok, good;
    busWrite(A_DIV, div);
    busWrite(A_MODE, 7);
    busWrite(A_LAST, last);
    for (int k = 0; k < 32; k++) busWrite(k, txp(k, last));
    base = capBits / 8;
    expHigh = div + 1;
    irq0 = irqCnt;
    bad0 = badHigh;
    busWrite(A_CTRL, 1);
    busRead(A_CNT, v);
    check(v == 0, "R3 counter cleared at start", v, 0);
    busRead(A_CTRL, v);
    check(v == 1, "R3 busy after start", v, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      busWrite(A_CTRL, 1);          // R8
      busWrite(A_LAST, 0);          // R9
      busWrite(A_DIV, div + 3);     // R9
      busWrite(31, 8'h5A);          // R9
      busWrite(0, 8'hC3);           // R9
    end
    for (int t = 0; t < 20000 && irqCnt == irq0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(irqCnt - irq0 == 1, "R6 single interrupt per block", irqCnt - irq0, 1);
    busRead(A_CTRL, v);
    check(v == 0, "R6 busy clear after block", v, 0);
    busRead(A_CNT, v);
    check(v == last, "R4 counter ends at final index", v, last);
    check(capBits / 8 - base == last + 1, "R4 byte count", capBits / 8 - base, last + 1);
    good = 1;
    for (int k = 0; k <= last; k++) if (capArr[k] !== txp(k, last)) good = 0;
    check(good == 1, "R3 bytes on line in index order MSB first", good, 1);
    good = 1;
    for (int k = 0; k < 32; k++) begin
      busRead(k, v);
      if (k <= last && v != int'(rxp(k))) good = 0;
      if (k > last && v != int'(txp(k, last))) good = 0;
    end
    check(good == 1, "R5 received bytes stored in place, upper entries kept", good, 1);
    check(badHigh == bad0, "R7 high phase length", badHigh - bad0, 0);
    if (poke) begin
      busRead(A_LAST, v);
      check(v == last, "R9 final index locked while busy", v, last);
      busRead(A_DIV, v);
      check(v == div, "R9 divider locked while busy", v, div);
      ok = 1;
    end
  endtask

  initial begin
    #760000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, irq0, rises0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(irq == 0 && sclk == 0 && mosi == 0, "R1 outputs low in reset", {irq, sclk, mosi}, 0);
    rstN = 1'b1;
    busRead(A_CTRL, v); check(v == 0, "R1 busy after reset", v, 0);
    busRead(A_CNT, v);  check(v == 0, "R1 counter after reset", v, 0);
    busRead(A_LAST, v); check(v == 0, "R1 final index after reset", v, 0);
    busRead(A_MODE, v); check(v == 0, "R1 mode after reset", v, 0);
    busRead(A_DIV, v);  check(v == 1, "R1 divider after reset", v, 1);

    // R10 register readback
    busWrite(A_MODE, 5);
    busRead(A_MODE, v); check(v == 5, "R10 mode bits", v, 5);
    busWrite(A_LAST, 8'hFD);
    busRead(A_LAST, v); check(v == 29, "R10 final index field 4:0", v, 29);

    // R2 incomplete mode rejects start
    for (int m = 0; m < 7; m++) begin
      busWrite(A_MODE, m);
      irq0 = irqCnt; rises0 = sclkRises;
      busWrite(A_CTRL, 1);
      repeat (10) @(negedge clk);
      busRead(A_CTRL, v);
      check(v == 0 && irqCnt == irq0 && sclkRises == rises0, "R2 start ignored for mode", m, 7);
    end

    // sweep every final index with several dividers
    for (int last = 0; last < 32; last++) runXfer(last, last % 3, 1'b0);
    runXfer(5, 4, 1'b0);
    runXfer(0, 7, 1'b0);
    // R8 / R9 busy-time writes
    runXfer(6, 1, 1'b1);
    runXfer(20, 0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule